// File: doc/BRIEF.md
# Armed Low-Power Wake Timer

This block counts down a programmed sleep interval and produces a wake request when the interval runs out. Software sets a 3-bit period multiplier and a unit-select bit in a configuration register. It then writes an arm strobe. The strobe captures those settings into a private countdown, so the register fields can be rewritten freely afterwards.

The countdown advances on a slow timebase enable (`rtc_tick`). It only advances while the device reports a sleep or display-only power mode. A prescaler turns slow ticks into units of 2.5 seconds or 1 minute. The interval is the period value times the selected unit.

After arming, the first three slow ticks are spent settling. This is why arming must happen at least three slow cycles before low power is entered. A brownout, or a return from a low-power mode to active mode, clears the timer and disarms it.

Top module: `lp_wake_timer`

## Requirements
- R1: After reset the configuration register reads 8'h01 (period 1, unit select 0), the control register reads 8'h00, and `wake_pulse` is 0.
- R2: Address 0 is the configuration register. Bits [2:0] hold the period and bit 3 holds the unit select. A write stores those four bits, and the register reads back `{4'b0, unit, period}`.
- R3: A write to address 1 with bit 0 set arms the timer. A write to address 1 with bit 0 clear does not arm it. On reads of address 1, bit 1 is the armed status and bit 0 always reads 0.
- R4: With the timer armed and the device in sleep (mode 2) or display-only (mode 3), `wake_pulse` rises one clock after slow tick number 3 + N*U counted from the arm write. N is the captured period. U is TICK_HZ*5/2 ticks when the unit select is 0 and TICK_HZ*60 ticks when it is 1.
- R5: The first three slow ticks after arming are consumed by a settling stage, whatever the power mode. No unit counting happens before they have elapsed.
- R6: An arm with period 0 behaves exactly like an arm with period 1.
- R7: `wake_pulse` is high for exactly one clock. From that edge on, the timer reads as disarmed.
- R8: Writing the configuration register while armed does not change the interval already in progress.
- R9: Brownout mode (mode 1) disarms the timer within one clock. Arm writes made during brownout are ignored.
- R10: An armed timer keeps its state in active mode (mode 0) without counting units. A change from sleep or display-only back to active disarms it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rtc_tick | input | 1 | One-clock enable per slow timebase cycle |
| pwr_mode | input | 2 | Power mode: 0 active, 1 brownout, 2 sleep, 3 display-only |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Combinational register read data |
| wake_pulse | output | 1 | Single-clock wake request |

## Verification
The assertions assume that `rtc_tick` is a one-clock enable, so each slow cycle is counted once. They also assume that every 2-bit `pwr_mode` value is meaningful, so a brownout code is never a glitch to be filtered.

The stimulus respects both assumptions:
- Every tick is a single-clock pulse followed by an idle clock.
- Mode changes and register writes are driven only at falling edges, in clocks that carry no tick.

Because of this, each expected wake tick count follows directly from 3 + N*U.

// File: rtl/wake_timer_pkg.sv
// Shared definitions for the low-power wake timer: power mode codes,
// countdown states and register map constants.
package wake_timer_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE   = 2'd0,
        MODE_BROWNOUT = 2'd1,
        MODE_SLEEP    = 2'd2,
        MODE_DISPLAY  = 2'd3
    } pwr_mode_e;

    typedef enum logic [1:0] {
        WT_IDLE   = 2'd0,
        WT_SETTLE = 2'd1,
        WT_COUNT  = 2'd2
    } wt_state_e;

    localparam int        PERIOD_W      = 3;
    localparam logic [1:0] ADDR_CFG     = 2'd0;
    localparam logic [1:0] ADDR_CTRL    = 2'd1;
    localparam int        CFG_UNIT_BIT  = 3;
    localparam int        CTRL_ARM_BIT  = 0;
    localparam int        CTRL_STAT_BIT = 1;

endpackage

// File: rtl/wake_regs.sv
// Register file for the wake timer: holds the period/unit configuration,
// decodes the write-only arm strobe and muxes read data.
// Assumes writes and reads are single-cycle with no handshake.
module wake_regs
    import wake_timer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [1:0]          rd_addr,
    input  logic                armed,
    output logic [PERIOD_W-1:0] period_q,
    output logic                unit_q,
    output logic                arm_req,
    output logic [DATA_W-1:0]   rd_data
);

    logic cfg_wr;
    assign cfg_wr = wr_en && (wr_addr == ADDR_CFG);

    // Store the configuration fields on a write to the config address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PERIOD_W'(1);
            unit_q   <= 1'b0;
        end else if (cfg_wr) begin
            period_q <= wr_data[PERIOD_W-1:0];
            unit_q   <= wr_data[CFG_UNIT_BIT];
        end
    end

    // Decode the arm strobe; it has no storage and never reads back.
    always_comb begin
        arm_req = wr_en && (wr_addr == ADDR_CTRL) && wr_data[CTRL_ARM_BIT];
    end

    // Build read data for the addressed register.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CFG: begin
                rd_data[PERIOD_W-1:0] = period_q;
                rd_data[CFG_UNIT_BIT] = unit_q;
            end
            ADDR_CTRL: rd_data[CTRL_STAT_BIT] = armed;
            default:   rd_data = '0;
        endcase
    end

    // R2 / R8: configuration only moves on a config write.
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(period_q) && $stable(unit_q)));

endmodule

// File: rtl/wake_prescaler.sv
// Unit prescaler: divides slow ticks into 2.5 s or 1 min units.
// Assumes the tick rate TICK_HZ is even so 2.5 s is a whole tick count.
module wake_prescaler #(
    parameter int TICK_HZ = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic unit_sel,
    input  logic step,
    output logic unit_done
);

    localparam int SHORT_TICKS = TICK_HZ * 5 / 2;
    localparam int LONG_TICKS  = TICK_HZ * 60;
    localparam int UNIT_W      = $clog2(LONG_TICKS + 1);
    localparam logic [UNIT_W-1:0] SHORT_LAST = UNIT_W'(SHORT_TICKS - 1);
    localparam logic [UNIT_W-1:0] LONG_LAST  = UNIT_W'(LONG_TICKS - 1);

    logic [UNIT_W-1:0] tick_cnt;
    logic [UNIT_W-1:0] last_val;

    // Select the terminal count for the captured unit.
    always_comb begin
        last_val  = unit_sel ? LONG_LAST : SHORT_LAST;
        unit_done = step && (tick_cnt == last_val);
    end

    // Count ticks inside the current unit, wrapping at the unit end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tick_cnt <= '0;
        end else if (step) begin
            tick_cnt <= unit_done ? '0 : tick_cnt + UNIT_W'(1);
        end
    end

    // R4: the in-unit count never passes the unit length.
    p_unit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= last_val);

endmodule

// File: rtl/wake_countdown.sv
// Countdown control: captures settings on arm, settles for SETTLE_TICKS
// slow ticks, counts units in low-power modes and fires the wake pulse.
// Assumes pwr_mode is synchronous to clk.
module wake_countdown
    import wake_timer_pkg::*;
#(
    parameter int SETTLE_TICKS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm_req,
    input  logic [PERIOD_W-1:0] period_in,
    input  logic                unit_in,
    input  logic                rtc_tick,
    input  logic [1:0]          pwr_mode,
    input  logic                unit_done,
    output logic                armed,
    output logic                unit_lat,
    output logic                count_step,
    output logic                presc_clear,
    output logic                wake_pulse
);

    localparam int SETTLE_W = $clog2(SETTLE_TICKS + 1);

    wt_state_e           state;
    logic [PERIOD_W-1:0] per_cnt;
    logic [SETTLE_W-1:0] settle_cnt;
    logic                prev_low;
    logic                low_now;
    logic                kill;

    // Classify the current power mode and detect disarm conditions.
    always_comb begin
        low_now     = (pwr_mode == MODE_SLEEP) || (pwr_mode == MODE_DISPLAY);
        kill        = (pwr_mode == MODE_BROWNOUT) || (prev_low && !low_now);
        armed       = (state != WT_IDLE);
        count_step  = rtc_tick && low_now && (state == WT_COUNT) && !kill && !arm_req;
        presc_clear = kill || arm_req || (state != WT_COUNT);
    end

    // Track whether the previous cycle was a low-power mode.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_low <= 1'b0;
        else        prev_low <= low_now;
    end

    // Main countdown sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= WT_IDLE;
            per_cnt    <= '0;
            settle_cnt <= '0;
            unit_lat   <= 1'b0;
            wake_pulse <= 1'b0;
        end else begin
            wake_pulse <= 1'b0;
            if (kill) begin
                state      <= WT_IDLE;
                per_cnt    <= '0;
                settle_cnt <= '0;
            end else if (arm_req) begin
                state      <= WT_SETTLE;
                per_cnt    <= (period_in == '0) ? PERIOD_W'(1) : period_in;
                unit_lat   <= unit_in;
                settle_cnt <= '0;
            end else begin
                case (state)
                    WT_SETTLE: if (rtc_tick) begin
                        if (settle_cnt == SETTLE_W'(SETTLE_TICKS - 1)) begin
                            state      <= WT_COUNT;
                            settle_cnt <= '0;
                        end else begin
                            settle_cnt <= settle_cnt + SETTLE_W'(1);
                        end
                    end
                    WT_COUNT: if (unit_done) begin
                        if (per_cnt == PERIOD_W'(1)) begin
                            wake_pulse <= 1'b1;
                            state      <= WT_IDLE;
                            per_cnt    <= '0;
                        end else begin
                            per_cnt <= per_cnt - PERIOD_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7: wake lasts one clock.
    p_wake_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R7: the timer is disarmed once it has woken.
    p_wake_disarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> !armed);

    // R9: brownout leaves the timer disarmed.
    p_brownout_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == MODE_BROWNOUT) |=> !armed);

    // R3: an accepted arm strobe arms the timer.
    p_arm_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_req && !kill) |=> armed);

    // R6: an armed timer always has a nonzero remaining period.
    p_count_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (per_cnt != '0));

    // R10: no unit progress while counting in active mode.
    p_hold_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == WT_COUNT) && (pwr_mode == MODE_ACTIVE) && !kill && !arm_req)
            |=> $stable(per_cnt));

endmodule

// File: rtl/lp_wake_timer.sv
// Top of the armed low-power wake timer: register file, unit prescaler
// and countdown sequencer. Assumes rtc_tick is a one-clock enable.
module lp_wake_timer
    import wake_timer_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int TICK_HZ      = 4,
    parameter int SETTLE_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_tick,
    input  logic [1:0]        pwr_mode,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wake_pulse
);

    logic [PERIOD_W-1:0] period_q;
    logic                unit_q;
    logic                arm_req;
    logic                armed;
    logic                unit_lat;
    logic                count_step;
    logic                presc_clear;
    logic                unit_done;

    wake_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .armed    (armed),
        .period_q (period_q),
        .unit_q   (unit_q),
        .arm_req  (arm_req),
        .rd_data  (rd_data)
    );

    wake_prescaler #(.TICK_HZ(TICK_HZ)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (presc_clear),
        .unit_sel  (unit_lat),
        .step      (count_step),
        .unit_done (unit_done)
    );

    wake_countdown #(.SETTLE_TICKS(SETTLE_TICKS)) u_cd (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_req     (arm_req),
        .period_in   (period_q),
        .unit_in     (unit_q),
        .rtc_tick    (rtc_tick),
        .pwr_mode    (pwr_mode),
        .unit_done   (unit_done),
        .armed       (armed),
        .unit_lat    (unit_lat),
        .count_step  (count_step),
        .presc_clear (presc_clear),
        .wake_pulse  (wake_pulse)
    );

endmodule

// File: tb/test_lp_wake_timer.sv
`timescale 1ns/1ps
module test_lp_wake_timer;

    localparam int TICK_HZ = 2;
    localparam int U_SHORT = TICK_HZ * 5 / 2;
    localparam int U_LONG  = TICK_HZ * 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rtc_tick = 1'b0;
    logic [1:0] pwr_mode = 2'd0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       wake_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lp_wake_timer #(.DATA_W(8), .TICK_HZ(TICK_HZ), .SETTLE_TICKS(3)) i_lp_wake_timer (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .pwr_mode(pwr_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wake_pulse(wake_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic tick();
        @(negedge clk);
        rtc_tick = 1'b1;
        @(negedge clk);
        rtc_tick = 1'b0;
    endtask

    // Ticks until wake or limit; n is the tick count at which wake appeared.
    task automatic run(input int limit, output int n, output bit got);
        n = 0; got = 0;
        while (!got && n < limit) begin
            tick();
            n++;
            if (wake_pulse) got = 1;
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        pwr_mode = m;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, n, exp_n, per_eff;
        bit got;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 cfg reset", v, 8'h01);
        rd(2'd1, v); chk("R1 ctrl reset", v, 8'h00);
        chk("R1 wake reset", int'(wake_pulse), 0);

        // R2 config field storage and readback
        wr(2'd0, 8'h0D); rd(2'd0, v); chk("R2 cfg readback", v, 8'h0D);
        wr(2'd0, 8'hF2); rd(2'd0, v); chk("R2 upper bits dropped", v, 8'h02);

        // R3 arm write without bit 0 does not arm
        wr(2'd1, 8'h02); rd(2'd1, v); chk("R3 no arm without bit0", v, 0);

        // R4/R5/R6/R7 sweep all periods and both units
        for (int u = 0; u < 2; u++) begin
            for (int p = 0; p < 8; p++) begin
                set_mode(2'd0);
                wr(2'd0, 8'((u << 3) | p));
                wr(2'd1, 8'h01);
                rd(2'd1, v); chk("R3 armed status, arm bit reads 0", v, 2);
                set_mode((p % 2 == 1) ? 2'd3 : 2'd2);
                per_eff = (p == 0) ? 1 : p;
                exp_n = 3 + per_eff * ((u == 1) ? U_LONG : U_SHORT);
                run(exp_n + 5, n, got);
                chk(p == 0 ? "R6 period zero as one" : "R4 R5 wake tick", n, exp_n);
                @(negedge clk);
                chk("R7 single-cycle wake", int'(wake_pulse), 0);
                rd(2'd1, v); chk("R7 disarmed after wake", v, 0);
            end
        end

        // R8 config rewrite during countdown has no effect
        set_mode(2'd0);
        wr(2'd0, 8'h02); wr(2'd1, 8'h01);
        set_mode(2'd2);
        for (int i = 0; i < 4; i++) tick();
        wr(2'd0, 8'h0F);
        run(40, n, got);
        chk("R8 interval kept", n + 4, 3 + 2 * U_SHORT);

        // R5/R10 settle in active, hold in active, then count in sleep
        set_mode(2'd0);
        wr(2'd0, 8'h01); wr(2'd1, 8'h01);
        for (int i = 0; i < 9; i++) tick();
        rd(2'd1, v); chk("R10 stays armed in active", v, 2);
        chk("R10 no wake in active", int'(wake_pulse), 0);
        set_mode(2'd2);
        run(U_SHORT + 5, n, got);
        chk("R5 settle consumed in active", n, U_SHORT);

        // R10 return to active disarms
        set_mode(2'd0);
        wr(2'd0, 8'h03); wr(2'd1, 8'h01);
        set_mode(2'd2);
        for (int i = 0; i < 4; i++) tick();
        set_mode(2'd0);
        @(negedge clk);
        rd(2'd1, v); chk("R10 exit disarms", v, 0);
        set_mode(2'd2);
        run(25, n, got);
        chk("R10 no wake after disarm", int'(got), 0);

        // R9 brownout disarms and blocks arming
        set_mode(2'd0);
        wr(2'd0, 8'h01); wr(2'd1, 8'h01);
        set_mode(2'd2);
        tick(); tick();
        set_mode(2'd1);
        @(negedge clk);
        rd(2'd1, v); chk("R9 brownout disarms", v, 0);
        wr(2'd1, 8'h01);
        rd(2'd1, v); chk("R9 arm ignored in brownout", v, 0);
        set_mode(2'd0);
        set_mode(2'd2);
        run(20, n, got);
        chk("R9 no wake after brownout", int'(got), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule